// File: doc/BRIEF.md
# Dual-Edge 4:1 Receive Deserializer

This block turns a serial bit stream into 4-bit parallel words. The stream runs at twice the rate of its clock, so a new bit is taken on every rising and every falling edge of the half-rate input clock. The deserialization is done in cascaded stages, each clocked more slowly than the one before it. The first stage splits the stream by clock edge into two half-rate paths. A divided clock at half the input clock frequency then carries each path through a second capture, and that capture uses both of its edges. No register ever runs at the full bit rate.

Each word is presented as two 2-bit lanes, A and B. The earliest bit of a word goes to A bit 0, the next to B bit 0, the third to A bit 1 and the last to B bit 1. The divided clock is driven out together with the lanes, and the lanes change only on its rising edge. A valid flag tells the receiving logic when the words have become meaningful after reset.

Top module: `ddr_deser4`

## Requirements
- R1: `word_clk` is held low while reset is applied. After reset it toggles on every falling edge of `clk_hr`, so one period of `word_clk` spans four serial bits.
- R2: A serial bit is sampled on every rising edge and on every falling edge of `clk_hr`. With a constant-0 stream both lanes read 0, with a constant-1 stream both lanes read 3, and with a stream alternating 1,0 starting on a rising-edge sample, `lane_a` reads 3 and `lane_b` reads 0.
- R3: Number the `clk_hr` edges so that a rising edge of `word_clk` occurs at edge e. The word presented at that rising edge holds the bits sampled at edges e-5, e-4, e-3 and e-2, with edge e-5 a rising edge. They appear in the order `lane_a[0]`, `lane_b[0]`, `lane_a[1]`, `lane_b[1]`.
- R4: `lane_a` and `lane_b` change only at a rising edge of `word_clk`. They hold their value for the rest of the `word_clk` period.
- R5: `word_vld` is low while reset is applied and at the first two rising edges of `word_clk` after reset. It goes high at the third rising edge.
- R6: Once high, `word_vld` stays high until reset is applied again.
- R7: Driving `rst_n` low forces `word_clk` and `word_vld` low at once, without waiting for a clock edge.
- R8: Release of `rst_n` is synchronized to rising edges of `clk_hr`. The first rising edge of `word_clk` comes on the falling edge of `clk_hr` that follows the second rising edge of `clk_hr` after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hr | input | 1 | Half-rate receive clock; both of its edges sample data |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data, one bit per `clk_hr` edge |
| lane_a | output | 2 | Word bits 0 and 2 (earliest bit in bit 0) |
| lane_b | output | 2 | Word bits 1 and 3 (second bit in bit 0) |
| word_vld | output | 1 | High once the lanes carry complete words |
| word_clk | output | 1 | Divided clock; lanes update on its rising edge |

## Verification
The assertions check on every cycle that the divided clock alternates at each rising `clk_hr` edge, that the lanes hold still during the low phase of `word_clk`, that `word_vld` rises only together with `word_clk` and never drops outside reset. Only the directed scenarios can show that each bit reaches the right lane bit under a PRBS-7 stream and under constant and alternating patterns. The same holds for the exact edge on which the divided clock starts after reset release, the count of edges before `word_vld` rises, and the immediate effect of a reset applied in mid-stream.

// File: rtl/ddrd_pkg.sv
`timescale 1ns/1ps
package ddrd_pkg;
  localparam int LANE_W    = 2;
  localparam int WORD_BITS = 2 * LANE_W;

  typedef struct packed {
    logic [LANE_W-1:0] a;
    logic [LANE_W-1:0] b;
  } lane_word_t;
endpackage

// File: rtl/ddrd_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts asynchronously, releases on rising clock edges.
module ddrd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh_q;
  logic [LAST:0] sh_d;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sh_d = {sh_q[LAST-1:0], 1'b1};
    end else begin : g_single
      always_comb sh_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[LAST];
endmodule

// File: rtl/ddrd_div2.sv
`timescale 1ns/1ps
// Toggle divider on the falling edge of the half-rate clock; resets low.
module ddrd_div2 (
  input  logic clk_hr,
  input  logic rst_n,
  output logic dclk
);
  logic dclk_q;
  logic dclk_d;

  always_comb dclk_d = ~dclk_q;

  always_ff @(negedge clk_hr or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk_d;
  end

  assign dclk = dclk_q;

  // R1: seen from rising edges, the divided clock alternates every cycle
  assert_div_alternates_R1: assert property (@(posedge clk_hr) disable iff (!rst_n)
    $past(rst_n) |-> (dclk_q != $past(dclk_q)));
endmodule

// File: rtl/ddrd_edge_split.sv
`timescale 1ns/1ps
// First stage: one path per clock edge. The falling-edge bit is moved to the
// rising edge so the next stage reads both paths while they are quiet.
module ddrd_edge_split (
  input  logic clk_hr,
  input  logic ser_in,
  output logic rise_bit,
  output logic fall_bit
);
  logic rise_q;
  logic fall_q;
  logic fall_rt_q;

  always_ff @(posedge clk_hr) rise_q <= ser_in;
  always_ff @(negedge clk_hr) fall_q <= ser_in;
  always_ff @(posedge clk_hr) fall_rt_q <= fall_q;

  assign rise_bit = rise_q;
  assign fall_bit = fall_rt_q;
endmodule

// File: rtl/ddrd_pair_stage.sv
`timescale 1ns/1ps
// Second stage on both edges of the divided clock, word register and valid flag.
module ddrd_pair_stage
  import ddrd_pkg::*;
#(
  parameter int VLD_WAIT = 2
) (
  input  logic       dclk,
  input  logic       rst_n,
  input  logic       rise_bit,
  input  logic       fall_bit,
  output lane_word_t word,
  output logic       word_vld
);
  localparam int CW = $clog2(VLD_WAIT + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(VLD_WAIT);

  logic       rp_first_q;   // rising path, earlier bit (divided rising edge)
  logic       rp_second_q;  // rising path, later bit (divided falling edge)
  logic       fp_first_q;   // falling path, earlier bit (divided falling edge)
  lane_word_t word_q;
  lane_word_t word_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic vld_q;
  logic vld_d;

  always_ff @(posedge dclk) rp_first_q <= rise_bit;

  always_ff @(negedge dclk) begin
    rp_second_q <= rise_bit;
    fp_first_q  <= fall_bit;
  end

  always_comb begin
    word_d.a = {rp_second_q, rp_first_q};
    word_d.b = {fall_bit, fp_first_q};
  end

  always_ff @(posedge dclk) word_q <= word_d;

  always_comb begin
    cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CW'(1);
    vld_d = vld_q | (cnt_q == CNT_TOP);
  end

  always_ff @(posedge dclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign word     = word_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/ddr_deser4.sv
`timescale 1ns/1ps
module ddr_deser4
  import ddrd_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int VLD_WAIT   = 2
) (
  input  logic              clk_hr,
  input  logic              rst_n,
  input  logic              ser_in,
  output logic [LANE_W-1:0] lane_a,
  output logic [LANE_W-1:0] lane_b,
  output logic              word_vld,
  output logic              word_clk
);
  logic       srst_n;
  logic       dclk;
  logic       rise_bit;
  logic       fall_bit;
  lane_word_t word;

  ddrd_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk(clk_hr), .arst_n(rst_n), .srst_n(srst_n)
  );

  ddrd_div2 div_i (
    .clk_hr(clk_hr), .rst_n(srst_n), .dclk(dclk)
  );

  ddrd_edge_split split_i (
    .clk_hr(clk_hr), .ser_in(ser_in), .rise_bit(rise_bit), .fall_bit(fall_bit)
  );

  ddrd_pair_stage #(.VLD_WAIT(VLD_WAIT)) pair_i (
    .dclk(dclk), .rst_n(srst_n), .rise_bit(rise_bit), .fall_bit(fall_bit),
    .word(word), .word_vld(word_vld)
  );

  assign lane_a   = word.a;
  assign lane_b   = word.b;
  assign word_clk = dclk;

  // R4: lanes are quiet across the low phase of the divided clock
  assert_lanes_hold_R4: assert property (@(posedge clk_hr) disable iff (!srst_n)
    ($past(srst_n) && !word_clk) |-> $stable({lane_a, lane_b}));

  // R5: the valid flag rises only together with a divided-clock rise
  assert_vld_on_word_edge_R5: assert property (@(posedge clk_hr) disable iff (!srst_n)
    ($past(srst_n) && $rose(word_vld)) |-> word_clk);

  // R6: valid never drops outside reset
  assert_vld_sticky_R6: assert property (@(posedge clk_hr) disable iff (!srst_n)
    ($past(srst_n) && $past(word_vld)) |-> word_vld);
endmodule

// File: tb/ddr_deser4_tb_top.sv
`timescale 1ns/1ps
module ddr_deser4_tb_top;
  logic       clk_hr;
  logic       rst_n;
  logic       ser_in;
  logic [1:0] lane_a;
  logic [1:0] lane_b;
  logic       word_vld;
  logic       word_clk;

  int total;
  int bad;
  int mode;          // 0 prbs7, 1 const0, 2 const1, 3 alternating 1,0
  int n_edge;
  bit hist [64];
  logic [6:0] lfsr;

  ddr_deser4 dut_i (
    .clk_hr(clk_hr), .rst_n(rst_n), .ser_in(ser_in),
    .lane_a(lane_a), .lane_b(lane_b), .word_vld(word_vld), .word_clk(word_clk)
  );

  initial clk_hr = 1'b0;
  always #2.5 clk_hr = ~clk_hr;   // 200 MHz; edge n is at 2.5*(n+1) ns

  // serial driver: bit n is set up 1.25 ns before edge n
  initial begin
    n_edge = 0;
    lfsr = 7'h5B;
    ser_in = 1'b0;
    #1.25;
    forever begin
      bit b;
      case (mode)
        1: b = 1'b0;
        2: b = 1'b1;
        3: b = ~n_edge[0];
        default: begin
          b = lfsr[6] ^ lfsr[5];
          lfsr = {lfsr[5:0], b};
        end
      endcase
      hist[n_edge % 64] = b;
      ser_in = b;
      n_edge++;
      #2.5;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0;
    repeat (6) begin
      @(negedge clk_hr); #0.5;
      chk(word_clk == 1'b0, "R1 word_clk low in reset", int'(word_clk), 0);
      chk(word_vld == 1'b0, "R5 word_vld low in reset", int'(word_vld), 0);
    end
  endtask

  // releases reset between edges and checks start-up timing (R8, R1, R5)
  task automatic t_release;
    @(negedge clk_hr); #1;
    rst_n = 1'b1;
    @(posedge clk_hr); #0.5;
    chk(word_clk == 1'b0, "R8 no divided edge before sync", int'(word_clk), 0);
    @(posedge clk_hr); #0.5;
    chk(word_clk == 1'b0, "R8 no divided edge at sync", int'(word_clk), 0);
    @(negedge clk_hr); #0.5;
    chk(word_clk == 1'b1, "R8 first divided rise", int'(word_clk), 1);
    chk(word_vld == 1'b0, "R5 vld low at first rise", int'(word_vld), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_hr); #0.5;
      chk(word_clk == i[0], "R1 divided clock toggles", int'(word_clk), i & 1);
      chk(word_vld == (i >= 3), "R5 vld timing", int'(word_vld), int'(i >= 3));
    end
  endtask

  // R3 mapping with R4 hold and R6 stickiness on every word
  task automatic t_words(input int nwords);
    for (int w = 0; w < nwords; w++) begin
      int e;
      logic [1:0] ea;
      logic [1:0] eb;
      @(posedge word_clk);
      e = $rtoi($realtime / 2.5 + 0.5) - 1;
      ea = {hist[(e - 3) % 64], hist[(e - 5) % 64]};
      eb = {hist[(e - 2) % 64], hist[(e - 4) % 64]};
      #1;
      chk(lane_a == ea, "R3 lane_a bit order", int'(lane_a), int'(ea));
      chk(lane_b == eb, "R3 lane_b bit order", int'(lane_b), int'(eb));
      chk(word_vld == 1'b1, "R6 vld stays high", int'(word_vld), 1);
      #3;
      chk(lane_a == ea && lane_b == eb, "R4 lanes hold in period",
          int'({lane_a, lane_b}), int'({ea, eb}));
    end
  endtask

  task automatic t_pattern(input int m, input logic [1:0] ea, input logic [1:0] eb);
    mode = m;
    repeat (3) @(posedge word_clk);
    repeat (4) begin
      @(posedge word_clk); #1;
      chk(lane_a == ea, "R2 lane_a fixed pattern", int'(lane_a), int'(ea));
      chk(lane_b == eb, "R2 lane_b fixed pattern", int'(lane_b), int'(eb));
    end
  endtask

  task automatic t_mid_reset;
    @(posedge word_clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk(word_clk == 1'b0, "R7 word_clk drops at once", int'(word_clk), 1'b0);
    chk(word_vld == 1'b0, "R7 word_vld drops at once", int'(word_vld), 1'b0);
    #20;
    chk(word_clk == 1'b0 && word_vld == 1'b0, "R7 held in reset",
        int'({word_clk, word_vld}), 0);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    mode = 0;
    rst_n = 1'b0;
    #20;
    t_reset_state();
    t_release();
    t_words(40);
    t_pattern(1, 2'b00, 2'b00);
    t_pattern(2, 2'b11, 2'b11);
    t_pattern(3, 2'b11, 2'b00);
    mode = 0;
    t_words(20);
    t_mid_reset();
    t_release();
    t_words(40);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule